// File: doc/BRIEF.md
# Multiplexed Address/Data Parallel Port Controller

This block connects a core-side request interface to an external parallel bus that uses one set of 16 pins for both address and data. The core issues a read or write with a 24-bit byte address and up to 16 bits of write data. The controller sequences the pins through an optional address-latch phase, a turnaround cycle for reads, and a read or write strobe. It then returns a one-cycle completion pulse with the read data. An external transparent latch captures the address portion while the latch-enable strobe is active.

The port has two data modes. In wide mode, address bits 15..0 are latched externally and data uses all 16 pins. In narrow mode, address bits 23..8 are latched externally. During the strobe, the upper pin byte carries address bits 7..0 and the lower pin byte carries one data byte. The controller remembers the last value it latched and skips the latch phase when the new access needs the same value. That memory is cleared by reset and by any change of data mode. The latch-enable polarity is programmable. When the port is disabled, all strobes stay idle, the pins are released and requests are refused, so the pins can serve as general-purpose flags.

Top module: `muxbus_port`

## Requirements
- R1: While reset is held, adOe is 2'b00, rdN and wrN are 1, ale is at its inactive level (0 when cfgAleLow=0), and rspDone is 0.
- R2: In wide mode (cfgWide=1), a latch phase is issued only when reqAddr[15:0] differs from the last latched value. During that phase adOut carries reqAddr[15:0] and adOe is 2'b11.
- R3: In narrow mode (cfgWide=0), a latch phase is issued only when reqAddr[23:8] differs from the last latched value, and that value is driven on adOut. During the strobe, adOut[15:8] carries reqAddr[7:0] and adOut[7:0] carries data. A narrow read returns {8'h00, adIn[7:0]}.
- R4: A read holds rdN low for S cycles, where S = cfgStrobeCycles, or 1 if that field is 0. rspRdata is adIn sampled in the last strobe cycle; in wide mode all 16 bits are used.
- R5: Every read strobe is preceded by one turnaround cycle with adOe[0]=0. During a read strobe and its turnaround, adOe is 2'b00 in wide mode and 2'b10 in narrow mode (bit 1 enables adOut[15:8], bit 0 enables adOut[7:0]).
- R6: A write holds wrN low for S cycles with adOe=2'b11. adOut carries reqWdata in wide mode, and {reqAddr[7:0], reqWdata[7:0]} in narrow mode. rdN and wrN are never low together.
- R7: A latch phase lasts A cycles, where A = cfgAleCycles, or 1 if that field is 0. rspDone is a single-cycle pulse that rises L clock edges after the accepting edge, where L = (A if a latch phase is issued, else 0) + (1 for a read, else 0) + S. The latch phase never overlaps a strobe.
- R8: ale is active high when cfgAleLow=0 and active low when cfgAleLow=1. It sits at the inactive level outside the latch phase.
- R9: Reset and any change of cfgWide invalidate the stored latched value, so the next access always issues a latch phase, even when the address bits would match.
- R10: While cfgEnable=0, reqReady is 0, requests are ignored (no strobe, no rspDone, stored latched value untouched), rdN=wrN=1, ale is inactive and adOe=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | 1 = port owns the pins; 0 = pins released for flag use |
| cfgWide | input | 1 | 1 = 16-bit data mode, 0 = 8-bit data mode |
| cfgAleLow | input | 1 | 1 = latch enable active low |
| cfgAleCycles | input | 4 | Latch-phase width in cycles (0 treated as 1) |
| cfgStrobeCycles | input | 4 | Read/write strobe width in cycles (0 treated as 1) |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted on this edge when reqValid is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Byte address |
| reqWdata | input | 16 | Write data (low byte only in 8-bit mode) |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read data, valid with rspDone |
| adOut | output | 16 | Address/data value driven to the pins |
| adOe | output | 2 | Per-byte output enable (bit 1 = upper byte) |
| adIn | input | 16 | Value sampled from the pins |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ale | output | 1 | Address-latch enable, programmable polarity |

## Verification
The embedded properties check these rules on every cycle:
- the output enable is off in the lowest byte lane whenever the read strobe is low;
- every read strobe is entered through a turnaround state;
- the read and write strobes never overlap, and neither overlaps the latch phase;
- the completion pulse lasts one cycle;
- a mode change clears the stored latched value;
- disabling returns the sequencer to idle and suppresses completion.

Only the bench scenarios can show that the latch phase is skipped exactly when the latched address portion repeats. They also show that an external latch plus memory model, rebuilt from the pins, recovers the right address and data in both modes. The exact strobe widths and completion latency for each configured count, the polarity change and the refusal of requests while disabled are likewise shown only by the scenarios.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ALE,
    S_TURN,
    S_STRB
  } port_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;      // register the accepted request
    logic aleDrive;     // drive latched address portion
    logic latchUpdate;  // remember the value just latched
    logic dataDrive;    // data phase (turnaround or strobe)
    logic rdSample;     // sample the pins into the read register
    logic doneSet;      // raise the completion pulse
  } dp_strobe_t;

  // strobes from control to the pin stage
  typedef struct packed {
    logic aleAct;
    logic rdAct;
    logic wrAct;
  } pin_strobe_t;

endpackage

// File: rtl/muxbus_dp.sv
module muxbus_dp
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWide,
  input  dp_strobe_t        dpSt,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic              addrMatch,
  output logic              xferWrite,
  output logic [DATA_W-1:0] adOut,
  output logic [1:0]        adOe,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone
);

  localparam int LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] wdataR;
  logic [DATA_W-1:0] lastLatch;
  logic              latchValid;
  logic              prevWide;
  logic [DATA_W-1:0] reqField;
  logic [DATA_W-1:0] heldField;

  assign reqField  = cfgWide ? reqAddr[DATA_W-1:0] : reqAddr[LANE_W +: DATA_W];
  assign heldField = cfgWide ? addrR[DATA_W-1:0]   : addrR[LANE_W +: DATA_W];
  assign addrMatch = latchValid && (prevWide == cfgWide) && (reqField == lastLatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR      <= '0;
      wdataR     <= '0;
      xferWrite  <= 1'b0;
      lastLatch  <= '0;
      latchValid <= 1'b0;
      prevWide   <= 1'b0;
      rspRdata   <= '0;
      rspDone    <= 1'b0;
    end else begin
      if (dpSt.capture) begin
        addrR     <= reqAddr;
        wdataR    <= reqWdata;
        xferWrite <= reqWrite;
      end
      prevWide <= cfgWide;
      if (prevWide != cfgWide) begin
        latchValid <= 1'b0;
      end else if (dpSt.latchUpdate) begin
        lastLatch  <= heldField;
        latchValid <= 1'b1;
      end
      if (dpSt.rdSample) begin
        rspRdata <= cfgWide ? adIn : {{LANE_W{1'b0}}, adIn[LANE_W-1:0]};
      end
      rspDone <= dpSt.doneSet;
    end
  end

  always_comb begin
    adOut = '0;
    adOe  = 2'b00;
    if (dpSt.aleDrive) begin
      adOut = heldField;
      adOe  = 2'b11;
    end else if (dpSt.dataDrive) begin
      if (cfgWide) begin
        adOut = xferWrite ? wdataR : '0;
        adOe  = xferWrite ? 2'b11 : 2'b00;
      end else begin
        adOut = {addrR[LANE_W-1:0], xferWrite ? wdataR[LANE_W-1:0] : {LANE_W{1'b0}}};
        adOe  = xferWrite ? 2'b11 : 2'b10;
      end
    end
  end

  // R9: a mode change leaves no valid latched value behind
  p_invalid_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWide != $past(cfgWide)) |=> !latchValid);

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic [CNT_W-1:0] cfgAleCycles,
  input  logic [CNT_W-1:0] cfgStrobeCycles,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             addrMatch,
  input  logic             xferWrite,
  output logic             reqReady,
  output dp_strobe_t       dpSt,
  output pin_strobe_t      pinSt
);

  port_state_t      state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [CNT_W-1:0] lenAle, lenStb;

  assign lenAle = (cfgAleCycles == '0) ? CNT_W'(1) : cfgAleCycles;
  assign lenStb = (cfgStrobeCycles == '0) ? CNT_W'(1) : cfgStrobeCycles;

  always_comb begin
    stateNxt         = state;
    cntNxt           = cnt;
    dpSt             = '0;
    dpSt.aleDrive    = (state == S_ALE);
    dpSt.dataDrive   = (state == S_TURN) || (state == S_STRB);
    if (!cfgEnable) begin
      stateNxt = S_IDLE;
      cntNxt   = '0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          dpSt.capture = 1'b1;
          if (!addrMatch) begin
            stateNxt = S_ALE;
            cntNxt   = lenAle - 1'b1;
          end else if (reqWrite) begin
            stateNxt = S_STRB;
            cntNxt   = lenStb - 1'b1;
          end else begin
            stateNxt = S_TURN;
          end
        end
        S_ALE: if (cnt == '0) begin
          dpSt.latchUpdate = 1'b1;
          if (xferWrite) begin
            stateNxt = S_STRB;
            cntNxt   = lenStb - 1'b1;
          end else begin
            stateNxt = S_TURN;
          end
        end else begin
          cntNxt = cnt - 1'b1;
        end
        S_TURN: begin
          stateNxt = S_STRB;
          cntNxt   = lenStb - 1'b1;
        end
        S_STRB: if (cnt == '0) begin
          dpSt.rdSample = !xferWrite;
          dpSt.doneSet  = 1'b1;
          stateNxt      = S_IDLE;
        end else begin
          cntNxt = cnt - 1'b1;
        end
        default: stateNxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  assign reqReady     = cfgEnable && (state == S_IDLE);
  assign pinSt.aleAct = (state == S_ALE);
  assign pinSt.rdAct  = (state == S_STRB) && !xferWrite;
  assign pinSt.wrAct  = (state == S_STRB) && xferWrite;

  // R5: a read strobe is always entered from the turnaround state
  p_turn_before_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STRB && $past(state) != S_STRB && !xferWrite) |-> ($past(state) == S_TURN));

  // R10: disabling returns the sequencer to idle
  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (state == S_IDLE));

endmodule

// File: rtl/muxbus_port.sv
module muxbus_port
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgWide,
  input  logic              cfgAleLow,
  input  logic [CNT_W-1:0]  cfgAleCycles,
  input  logic [CNT_W-1:0]  cfgStrobeCycles,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic [DATA_W-1:0] adOut,
  output logic [1:0]        adOe,
  input  logic [DATA_W-1:0] adIn,
  output logic              rdN,
  output logic              wrN,
  output logic              ale
);

  dp_strobe_t  dpSt;
  pin_strobe_t pinSt;
  logic        addrMatch;
  logic        xferWrite;
  logic [1:0]  oeRaw;

  muxbus_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable),
    .cfgAleCycles(cfgAleCycles), .cfgStrobeCycles(cfgStrobeCycles),
    .reqValid(reqValid), .reqWrite(reqWrite), .addrMatch(addrMatch),
    .xferWrite(xferWrite), .reqReady(reqReady), .dpSt(dpSt), .pinSt(pinSt)
  );

  muxbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWide(cfgWide), .dpSt(dpSt),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .adIn(adIn),
    .addrMatch(addrMatch), .xferWrite(xferWrite), .adOut(adOut), .adOe(oeRaw),
    .rspRdata(rspRdata), .rspDone(rspDone)
  );

  assign adOe = cfgEnable ? oeRaw : 2'b00;
  assign rdN  = !(cfgEnable && pinSt.rdAct);
  assign wrN  = !(cfgEnable && pinSt.wrAct);
  assign ale  = (cfgEnable && pinSt.aleAct) ^ cfgAleLow;

  // R5: the low byte lane is released whenever the read strobe is low
  p_oe_off_at_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe[0]);

  // R6: read and write strobes never overlap
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R7: latch phase and strobes are exclusive
  p_ale_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ale != cfgAleLow) |-> (rdN && wrN));

  // R10: no completion once the port is given up
  p_disabled_nodone_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !rspDone);

endmodule

// File: tb/muxbus_port_tb.sv
module muxbus_port_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgEnable, cfgWide, cfgAleLow;
  logic [3:0]  cfgAleCycles, cfgStrobeCycles;
  logic        reqValid, reqReady, reqWrite;
  logic [23:0] reqAddr;
  logic [15:0] reqWdata;
  logic        rspDone;
  logic [15:0] rspRdata, adOut, adIn;
  logic [1:0]  adOe;
  logic        rdN, wrN, ale;

  int nTests = 0;
  int nFail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxbus_port u_dut (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgWide(cfgWide),
    .cfgAleLow(cfgAleLow), .cfgAleCycles(cfgAleCycles), .cfgStrobeCycles(cfgStrobeCycles),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspDone(rspDone), .rspRdata(rspRdata), .adOut(adOut),
    .adOe(adOe), .adIn(adIn), .rdN(rdN), .wrN(wrN), .ale(ale)
  );

  function automatic logic [15:0] memWord(input logic [23:0] a);
    return a[15:0] ^ {a[23:16], 8'h00} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // external latch + memory model, sampled away from the active edge
  logic [15:0] latchQ = '0;
  logic        prevAleOn = 1'b0, prevRdN = 1'b1;
  logic [1:0]  prevOe = 2'b00;
  int          alePulses = 0, aleCyc = 0, rdCyc = 0, wrCyc = 0, viol = 0;
  logic [23:0] wAddr = '0;
  logic [15:0] wData = '0;

  always @(negedge clk) begin
    logic aleOn;
    logic [15:0] narrowWord;
    aleOn = (ale == !cfgAleLow);
    if (aleOn) begin
      aleCyc++;
      if (!prevAleOn) alePulses++;
      latchQ = adOut;
      if (adOe != 2'b11) viol++;
    end
    if (!rdN) begin
      rdCyc++;
      if (adOe != (cfgWide ? 2'b00 : 2'b10)) viol++;
      if (prevRdN && prevOe != (cfgWide ? 2'b00 : 2'b10)) viol++;
    end
    if (!wrN) begin
      wrCyc++;
      if (adOe != 2'b11) viol++;
      wAddr = cfgWide ? {8'h00, latchQ} : {latchQ, adOut[15:8]};
      wData = cfgWide ? adOut : {8'h00, adOut[7:0]};
    end
    narrowWord = memWord({latchQ, adOut[15:8]});
    adIn = cfgWide ? memWord({8'h00, latchQ}) : {8'hEE, narrowWord[7:0]};
    prevAleOn = aleOn;
    prevRdN   = rdN;
    prevOe    = adOe;
  end

  function automatic int effCnt(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  task automatic xfer(input bit wide, input bit wr, input logic [23:0] addr,
                      input logic [15:0] wd, input bit expAle, input string tag);
    int lat, pulses0, expA, expS;
    logic [23:0] expAddr;
    expA = effCnt(cfgAleCycles);
    expS = effCnt(cfgStrobeCycles);
    @(negedge clk); #1;
    cfgWide = wide; reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    pulses0 = alePulses; aleCyc = 0; rdCyc = 0; wrCyc = 0; viol = 0;
    @(posedge clk); #1;
    reqValid = 1'b0;
    lat = 0;
    @(negedge clk); #1;
    while (!rspDone && lat < 100) begin
      @(negedge clk); #1;
      lat++;
    end
    chk(alePulses - pulses0 == (expAle ? 1 : 0), tag, alePulses - pulses0, expAle);
    chk(aleCyc == (expAle ? expA : 0), "R7", aleCyc, expAle ? expA : 0);
    chk(lat == (expAle ? expA : 0) + (wr ? 0 : 1) + expS, "R7", lat,
        (expAle ? expA : 0) + (wr ? 0 : 1) + expS);
    chk(viol == 0, "R5", viol, 0);
    expAddr = wide ? {8'h00, addr[15:0]} : addr;
    if (wr) begin
      chk(wrCyc == expS && rdCyc == 0, "R6", wrCyc, expS);
      chk(wAddr == expAddr, wide ? "R2" : "R3", wAddr, expAddr);
      chk(wData == (wide ? wd : {8'h00, wd[7:0]}), "R6", wData, wide ? wd : {8'h00, wd[7:0]});
    end else begin
      logic [15:0] mw;
      mw = memWord(expAddr);
      chk(rdCyc == expS && wrCyc == 0, "R4", rdCyc, expS);
      chk(rspRdata == (wide ? mw : {8'h00, mw[7:0]}), wide ? "R4" : "R3",
          rspRdata, wide ? mw : {8'h00, mw[7:0]});
    end
  endtask

  typedef struct packed {
    bit          wide;
    bit          wr;
    logic [23:0] addr;
    logic [15:0] wdata;
    bit          ale;
    bit          modeSwap;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b0, 24'h001234, 16'h0000, 1'b1, 1'b1},
    '{1'b1, 1'b1, 24'h001234, 16'hBEEF, 1'b0, 1'b0},
    '{1'b1, 1'b0, 24'h051234, 16'h0000, 1'b0, 1'b0},
    '{1'b1, 1'b0, 24'h001235, 16'h0000, 1'b1, 1'b0},
    '{1'b0, 1'b1, 24'h123456, 16'h00A7, 1'b1, 1'b1},
    '{1'b0, 1'b0, 24'h1234FF, 16'h0000, 1'b0, 1'b0},
    '{1'b0, 1'b0, 24'h123556, 16'h0000, 1'b1, 1'b0},
    '{1'b0, 1'b1, 24'h1235AA, 16'hFF3C, 1'b0, 1'b0},
    '{1'b1, 1'b0, 24'h001235, 16'h0000, 1'b1, 1'b1},
    '{1'b1, 1'b0, 24'h001235, 16'h0000, 1'b0, 1'b0}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int bad;
    rstN = 1'b0; cfgEnable = 1'b1; cfgWide = 1'b1; cfgAleLow = 1'b0;
    cfgAleCycles = 4'd2; cfgStrobeCycles = 4'd3;
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(adOe == 2'b00 && rdN && wrN && !ale && !rspDone, "R1",
        {adOe, rdN, wrN, ale, rspDone}, 6'b001100);
    rstN = 1'b1;

    foreach (VECS[i]) begin
      xfer(VECS[i].wide, VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].ale,
           VECS[i].modeSwap ? "R9" : (VECS[i].wide ? "R2" : "R3"));
    end

    // R10: requests ignored while the port is given up
    @(negedge clk); #1;
    cfgEnable = 1'b0; reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 24'h00FFFF;
    aleCyc = 0; rdCyc = 0; wrCyc = 0; bad = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); #1;
      if (reqReady || rspDone || adOe != 2'b00 || !rdN || !wrN || ale != cfgAleLow) bad++;
    end
    chk(bad == 0 && aleCyc == 0 && wrCyc == 0, "R10", bad + aleCyc + wrCyc, 0);
    reqValid = 1'b0; cfgEnable = 1'b1;
    xfer(1'b1, 1'b0, 24'h001235, 16'h0000, 1'b0, "R10");

    // R8: active-low latch enable
    cfgAleLow = 1'b1;
    @(negedge clk); #1;
    chk(ale == 1'b1, "R8", ale, 1);
    xfer(1'b1, 1'b0, 24'h00ABCD, 16'h0000, 1'b1, "R8");

    // R7: other widths, zero strobe count behaves as one
    cfgAleCycles = 4'd3; cfgStrobeCycles = 4'd0;
    xfer(1'b1, 1'b0, 24'h00ABCE, 16'h0000, 1'b1, "R7");
    xfer(1'b1, 1'b1, 24'h00ABCE, 16'h1357, 1'b0, "R7");

    // R9: reset clears the stored latched value
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    xfer(1'b1, 1'b0, 24'h00ABCE, 16'h0000, 1'b1, "R9");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule